// File: doc/BRIEF.md
# Multi-Issue Wavefront Issue Scheduler

This block is the issue stage of a compute unit built from several SIMD units, each holding a fixed pool of wavefront slots. In every cycle it chooses one SIMD to serve. From the ready wavefronts of that SIMD it then grants up to five instructions at once, one to each execution port. The grants go to a scalar ALU port, a vector port, a memory port, a branch port, and a second vector port. The second vector port is used only when two different wavefronts both have a single-precision vector operation ready. Fetch, decode and the execution units sit outside the block. The block sees a ready flag and a 3-bit operation-kind code for each wavefront slot. It returns the served SIMD and one grant (valid plus wavefront index) per port. Every port lives in the same cycle as its inputs.

Inside a port, the wavefront that has waited longest wins. Each wavefront slot has a small saturating age counter that restarts when the wavefront is granted. The SIMD order is round-robin and skips SIMDs with nothing issuable. After a vector issue, a per-SIMD busy counter keeps further vector work off that SIMD for the next cycles.

Top module: `wave_issue_sched`

## Requirements
- R1: `issue_vld` is 1 exactly when some SIMD has an eligible wavefront. `issue_simd` is then the first such SIMD found by searching upward, with wrap, from a round-robin pointer. After an issue the pointer moves to the SIMD after the served one. In a cycle with no issue the pointer stays put.
- R2: Kind codes are 0 scalar, 1 vector, 2 vector FP32, 3 memory and 4 branch. Port bits are 0 scalar, 1 vector, 2 paired FP32, 3 memory and 4 branch. Port p's wavefront index sits in `gnt_wave[5p+4:5p]`. Ports 0, 3 and 4 each grant an eligible wavefront of kind 0, 3 and 4 respectively in the served SIMD.
- R3: Each wavefront slot has an age that starts at 0 on reset. In every cycle the slot is not granted, its age goes up by 1 and saturates at 2^AGE_W-1 (15 by default). A granted slot returns to 0. On every port, the candidate with the largest age wins, and a tie goes to the lowest index.
- R4: Port 1 grants the oldest eligible wavefront of kind 1 or kind 2.
- R5: Port 2 is valid only when port 1 granted a kind-2 wavefront and a different eligible kind-2 wavefront exists. Port 2 then takes the oldest of the remaining kind-2 wavefronts.
- R6: Suppose SIMD s receives a port-1 grant in cycle t. Then no kind-1 or kind-2 wavefront of s is eligible before cycle t+VEC_CYCLES, which is t+4 by default. While the SIMD is blocked this way, such wavefronts also do not count toward selecting s.
- R7: No wavefront receives more than one grant in a cycle. At most five grants are given per cycle.
- R8: A wavefront with its ready flag low is never granted. Neither is a wavefront whose kind code is 5, 6 or 7.
- R9: While `rst` is high at a rising edge, the pointer, all ages and all busy counters return to 0. In the first cycle after reset, ties are therefore settled purely by the lowest index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wave_rdy | input | NUM_SIMD*NUM_WAVE | Ready flag per wavefront; bit s*NUM_WAVE+w |
| wave_kind | input | NUM_SIMD*NUM_WAVE*3 | Operation kind per wavefront; field (s*NUM_WAVE+w)*3 |
| issue_vld | output | 1 | A SIMD is served this cycle |
| issue_simd | output | SIMD_W | Index of the served SIMD |
| gnt_vld | output | 5 | Grant valid per port |
| gnt_wave | output | 5*WAVE_W | Granted wavefront index per port |

## Verification
The paired FP32 grant and the vector busy window can both land on the same SIMD. They are provoked together by a phase in which only one SIMD holds work, all of it vector and mostly FP32. After a two-way FP32 issue, the next three cycles must show no issue at all. The fourth cycle must pair again, this time with the oldest pair. In a separate phase, scalar, memory and branch grants fall in the same cycle as a pair. There the bench judges both that every grant goes to a distinct wavefront and that the age ordering holds on each port independently. The bench decides every one of these outcomes from its own model of ages, busy counters and the pointer.

// File: rtl/wis_pkg.sv
package wis_pkg;

    localparam int OP_W     = 3;
    localparam int NUM_PORT = 5;

    localparam int PORT_SCALAR = 0;
    localparam int PORT_VEC    = 1;
    localparam int PORT_PAIR   = 2;
    localparam int PORT_MEM    = 3;
    localparam int PORT_BRANCH = 4;

    typedef enum logic [OP_W-1:0] {
        OP_SCALAR = 3'd0,
        OP_VECTOR = 3'd1,
        OP_VF32   = 3'd2,
        OP_MEM    = 3'd3,
        OP_BRANCH = 3'd4
    } op_kind_e;

    function automatic logic kind_valid(input logic [OP_W-1:0] k);
        return k <= OP_BRANCH;
    endfunction

    function automatic logic kind_is_vec(input logic [OP_W-1:0] k);
        return (k == OP_VECTOR) || (k == OP_VF32);
    endfunction

    // which kinds each execution port accepts
    function automatic logic port_takes(input int p, input logic [OP_W-1:0] k);
        case (p)
            PORT_SCALAR: return k == OP_SCALAR;
            PORT_VEC:    return kind_is_vec(k);
            PORT_PAIR:   return k == OP_VF32;
            PORT_MEM:    return k == OP_MEM;
            PORT_BRANCH: return k == OP_BRANCH;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wis_oldest_pick.sv
module wis_oldest_pick #(
    parameter int NUM_WAVE = 24,
    parameter int AGE_W    = 4,
    parameter int IDX_W    = 5
) (
    input  logic [NUM_WAVE-1:0]       cand,
    input  logic [NUM_WAVE*AGE_W-1:0] ages,
    output logic                      found,
    output logic [IDX_W-1:0]          idx
);
    logic [AGE_W-1:0] best;

    // strict greater-than keeps the lowest index on equal ages
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int w = 0; w < NUM_WAVE; w++) begin
            if (cand[w] && (!found || (ages[w*AGE_W +: AGE_W] > best))) begin
                found = 1'b1;
                idx   = IDX_W'(w);
                best  = ages[w*AGE_W +: AGE_W];
            end
        end
    end
endmodule

// File: rtl/wis_rr_select.sv
module wis_rr_select #(
    parameter int NUM_SIMD = 4,
    parameter int SIMD_W   = 2
) (
    input  logic [SIMD_W-1:0]   ptr,
    input  logic [NUM_SIMD-1:0] any,
    output logic                found,
    output logic [SIMD_W-1:0]   sel
);
    always_comb begin
        found = 1'b0;
        sel   = ptr;
        for (int k = 0; k < NUM_SIMD; k++) begin
            int c;
            c = int'(ptr) + k;
            if (c >= NUM_SIMD) c = c - NUM_SIMD;
            if (!found && any[c]) begin
                found = 1'b1;
                sel   = SIMD_W'(c);
            end
        end
    end
endmodule

// File: rtl/wis_vec_busy.sv
module wis_vec_busy #(
    parameter int VEC_CYCLES = 4,
    localparam int CNT_W = (VEC_CYCLES > 2) ? $clog2(VEC_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CNT_W'(VEC_CYCLES - 1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_SIMD   = 4,
    parameter int NUM_WAVE   = 24,
    parameter int AGE_W      = 4,
    parameter int VEC_CYCLES = 4,
    localparam int SIMD_W = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
    localparam int WAVE_W = (NUM_WAVE > 1) ? $clog2(NUM_WAVE) : 1,
    localparam int SLOTS  = NUM_SIMD * NUM_WAVE
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [SLOTS-1:0]           wave_rdy,
    input  logic [SLOTS*OP_W-1:0]      wave_kind,
    output logic                       issue_vld,
    output logic [SIMD_W-1:0]          issue_simd,
    output logic [NUM_PORT-1:0]        gnt_vld,
    output logic [NUM_PORT*WAVE_W-1:0] gnt_wave
);
    typedef logic [AGE_W-1:0] age_t;

    age_t                               age_q [NUM_SIMD][NUM_WAVE];
    logic [SIMD_W-1:0]                  rr_q, rr_next, sel;
    logic [NUM_SIMD-1:0]                simd_busy, simd_any;
    logic [NUM_SIMD-1:0][NUM_WAVE-1:0]  elig;
    logic [NUM_WAVE-1:0]                elig_row, won;
    logic [OP_W-1:0]                    kind_row [NUM_WAVE];
    logic [NUM_WAVE*AGE_W-1:0]          age_row;
    logic                               vec_found, vec_is_f32;
    logic [WAVE_W-1:0]                  vec_idx;

    // per-SIMD vector occupancy
    for (genvar s = 0; s < NUM_SIMD; s++) begin : g_busy
        wis_vec_busy #(.VEC_CYCLES(VEC_CYCLES)) u_busy (
            .clk  (clk),
            .rst  (rst),
            .load (issue_vld && (sel == SIMD_W'(s)) && gnt_vld[PORT_VEC]),
            .busy (simd_busy[s])
        );
    end

    // eligibility: ready, known kind, and no vector work on a busy SIMD
    always_comb begin
        for (int s = 0; s < NUM_SIMD; s++) begin
            for (int w = 0; w < NUM_WAVE; w++) begin
                logic [OP_W-1:0] k;
                k = wave_kind[(s*NUM_WAVE + w)*OP_W +: OP_W];
                elig[s][w] = wave_rdy[s*NUM_WAVE + w] && kind_valid(k)
                             && !(kind_is_vec(k) && simd_busy[s]);
            end
            simd_any[s] = |elig[s];
        end
    end

    wis_rr_select #(.NUM_SIMD(NUM_SIMD), .SIMD_W(SIMD_W)) u_rr (
        .ptr   (rr_q),
        .any   (simd_any),
        .found (issue_vld),
        .sel   (sel)
    );

    assign issue_simd = sel;
    assign rr_next    = (sel == SIMD_W'(NUM_SIMD - 1)) ? '0 : sel + 1'b1;

    // view of the served SIMD
    always_comb begin
        elig_row = elig[sel];
        for (int w = 0; w < NUM_WAVE; w++) begin
            kind_row[w]               = wave_kind[(int'(sel)*NUM_WAVE + w)*OP_W +: OP_W];
            age_row[w*AGE_W +: AGE_W] = age_q[sel][w];
        end
    end

    assign vec_is_f32 = vec_found && (kind_row[vec_idx] == OP_VF32);

    // one oldest-first picker per execution port
    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        logic [NUM_WAVE-1:0] cand;
        logic                found;
        logic [WAVE_W-1:0]   idx;

        if (p == PORT_PAIR) begin : g_pair
            always_comb begin
                for (int w = 0; w < NUM_WAVE; w++)
                    cand[w] = elig_row[w] && port_takes(p, kind_row[w])
                              && vec_is_f32 && (WAVE_W'(w) != vec_idx);
            end
        end else begin : g_solo
            always_comb begin
                for (int w = 0; w < NUM_WAVE; w++)
                    cand[w] = elig_row[w] && port_takes(p, kind_row[w]);
            end
        end

        wis_oldest_pick #(.NUM_WAVE(NUM_WAVE), .AGE_W(AGE_W), .IDX_W(WAVE_W)) u_pick (
            .cand  (cand),
            .ages  (age_row),
            .found (found),
            .idx   (idx)
        );

        if (p == PORT_VEC) begin : g_tap
            assign vec_found = found;
            assign vec_idx   = idx;
        end

        assign gnt_vld[p]                   = found;
        assign gnt_wave[p*WAVE_W +: WAVE_W] = idx;
    end

    always_comb begin
        won = '0;
        for (int p = 0; p < NUM_PORT; p++)
            if (gnt_vld[p]) won[gnt_wave[p*WAVE_W +: WAVE_W]] = 1'b1;
    end

    // pointer and age state
    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
            for (int s = 0; s < NUM_SIMD; s++)
                for (int w = 0; w < NUM_WAVE; w++)
                    age_q[s][w] <= '0;
        end else begin
            if (issue_vld) rr_q <= rr_next;
            for (int s = 0; s < NUM_SIMD; s++)
                for (int w = 0; w < NUM_WAVE; w++) begin
                    if (issue_vld && (sel == SIMD_W'(s)) && won[w])
                        age_q[s][w] <= '0;
                    else if (age_q[s][w] != '1)
                        age_q[s][w] <= age_q[s][w] + 1'b1;
                end
        end
    end
endmodule

// File: rtl/wis_checker.sv
module wis_checker
    import wis_pkg::*;
#(
    parameter int NUM_SIMD   = 4,
    parameter int NUM_WAVE   = 24,
    parameter int VEC_CYCLES = 4,
    localparam int SIMD_W = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
    localparam int WAVE_W = (NUM_WAVE > 1) ? $clog2(NUM_WAVE) : 1,
    localparam int SLOTS  = NUM_SIMD * NUM_WAVE,
    localparam int GAP_W  = $clog2(VEC_CYCLES + 1)
) (
    input logic                       clk,
    input logic                       rst,
    input logic [SLOTS-1:0]           wave_rdy,
    input logic [SLOTS*OP_W-1:0]      wave_kind,
    input logic                       issue_vld,
    input logic [SIMD_W-1:0]          issue_simd,
    input logic [NUM_PORT-1:0]        gnt_vld,
    input logic [NUM_PORT*WAVE_W-1:0] gnt_wave
);
    logic             rdy_ok, kind_ok, pair_ok, distinct_ok, gap_ok;
    logic [GAP_W-1:0] since_q [NUM_SIMD];

    always_comb begin
        rdy_ok  = 1'b1;
        kind_ok = 1'b1;
        for (int p = 0; p < NUM_PORT; p++) begin
            int wi;
            int fl;
            wi = int'(gnt_wave[p*WAVE_W +: WAVE_W]);
            fl = int'(issue_simd)*NUM_WAVE + wi;
            if (gnt_vld[p]) begin
                if (wi >= NUM_WAVE || fl >= SLOTS || !wave_rdy[fl]) rdy_ok = 1'b0;
                else if (!port_takes(p, wave_kind[fl*OP_W +: OP_W])) kind_ok = 1'b0;
            end
        end
    end

    always_comb begin
        int vi;
        vi = int'(issue_simd)*NUM_WAVE + int'(gnt_wave[PORT_VEC*WAVE_W +: WAVE_W]);
        pair_ok = !gnt_vld[PORT_PAIR] ||
                  (gnt_vld[PORT_VEC] && vi < SLOTS &&
                   wave_kind[vi*OP_W +: OP_W] == OP_VF32);
        distinct_ok = 1'b1;
        for (int a = 0; a < NUM_PORT; a++)
            for (int b = a + 1; b < NUM_PORT; b++)
                if (gnt_vld[a] && gnt_vld[b] &&
                    gnt_wave[a*WAVE_W +: WAVE_W] == gnt_wave[b*WAVE_W +: WAVE_W])
                    distinct_ok = 1'b0;
    end

    // cycles since the last vector grant, per SIMD
    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_SIMD; s++) begin
            if (rst)
                since_q[s] <= GAP_W'(VEC_CYCLES);
            else if (issue_vld && gnt_vld[PORT_VEC] && issue_simd == SIMD_W'(s))
                since_q[s] <= GAP_W'(1);
            else if (since_q[s] < GAP_W'(VEC_CYCLES))
                since_q[s] <= since_q[s] + 1'b1;
        end
    end

    assign gap_ok = !gnt_vld[PORT_VEC] || (since_q[issue_simd] >= GAP_W'(VEC_CYCLES));

    p_grant_needs_issue_r1: assert property (@(posedge clk) disable iff (rst)
        (|gnt_vld) |-> issue_vld);
    p_kind_match_r2: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> kind_ok);
    p_pair_needs_f32_r5: assert property (@(posedge clk) disable iff (rst)
        gnt_vld[PORT_PAIR] |-> pair_ok);
    p_vec_gap_r6: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> gap_ok);
    p_distinct_waves_r7: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> distinct_ok);
    p_grant_ready_r8: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> rdy_ok);
endmodule

bind wave_issue_sched wis_checker #(
    .NUM_SIMD   (NUM_SIMD),
    .NUM_WAVE   (NUM_WAVE),
    .VEC_CYCLES (VEC_CYCLES)
) u_wis_chk (
    .clk        (clk),
    .rst        (rst),
    .wave_rdy   (wave_rdy),
    .wave_kind  (wave_kind),
    .issue_vld  (issue_vld),
    .issue_simd (issue_simd),
    .gnt_vld    (gnt_vld),
    .gnt_wave   (gnt_wave)
);

// File: tb/wave_issue_sched_tb.sv
`timescale 1ns/1ps
module wave_issue_sched_tb_top;
    localparam int NS = 4;
    localparam int NW = 24;
    localparam int AMAX = 15;
    localparam int VC = 4;
    localparam int NP = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NS*NW-1:0]  wave_rdy = '0;
    logic [NS*NW*3-1:0] wave_kind = '0;
    logic              issue_vld;
    logic [1:0]        issue_simd;
    logic [NP-1:0]     gnt_vld;
    logic [NP*5-1:0]   gnt_wave;

    wave_issue_sched dut_i (
        .clk(clk), .rst(rst), .wave_rdy(wave_rdy), .wave_kind(wave_kind),
        .issue_vld(issue_vld), .issue_simd(issue_simd),
        .gnt_vld(gnt_vld), .gnt_wave(gnt_wave)
    );

    always #2.5 clk = ~clk;

    int  nchk = 0, nfail = 0;
    bit  done = 0;
    bit  rdy [NS][NW];
    int  typ [NS][NW];
    int  age [NS][NW];
    int  busy [NS];
    int  ptr;
    bit  exp_issue;
    int  exp_simd;
    int  exp_wave [NP];
    string port_tag [NP] = '{"R2", "R4", "R5", "R2", "R2"};

    task automatic chk(int got, int exp, string tag, string ph, string what);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s (%s) %s: got %0d expected %0d", tag, ph, what, got, exp);
        end
    endtask

    function automatic bit elig(int s, int w);
        bit v = (typ[s][w] == 1) || (typ[s][w] == 2);
        return rdy[s][w] && typ[s][w] <= 4 && !(v && busy[s] > 0);
    endfunction

    function automatic bit takes(int p, int t);
        case (p)
            0: return t == 0;
            1: return t == 1 || t == 2;
            2: return t == 2;
            3: return t == 3;
            default: return t == 4;
        endcase
    endfunction

    function automatic int pick(int s, int p, int excl);
        int best = -1;
        for (int w = 0; w < NW; w++)
            if (elig(s, w) && takes(p, typ[s][w]) && w != excl &&
                (best < 0 || age[s][w] > age[s][best])) best = w;
        return best;
    endfunction

    task automatic model_reset();
        ptr = 0;
        for (int s = 0; s < NS; s++) begin
            busy[s] = 0;
            for (int w = 0; w < NW; w++) age[s][w] = 0;
        end
    endtask

    task automatic model_eval();
        exp_issue = 0; exp_simd = 0;
        for (int p = 0; p < NP; p++) exp_wave[p] = -1;
        for (int k = 0; k < NS && !exp_issue; k++) begin
            int s = (ptr + k) % NS;
            for (int w = 0; w < NW; w++) if (elig(s, w)) exp_issue = 1;
            if (exp_issue) exp_simd = s;
        end
        if (exp_issue) begin
            for (int p = 0; p < NP; p++) if (p != 2) exp_wave[p] = pick(exp_simd, p, -1);
            if (exp_wave[1] >= 0 && typ[exp_simd][exp_wave[1]] == 2)
                exp_wave[2] = pick(exp_simd, 2, exp_wave[1]);
        end
    endtask

    task automatic model_update();
        for (int s = 0; s < NS; s++) begin
            for (int w = 0; w < NW; w++) begin
                bit g = 0;
                if (exp_issue && s == exp_simd)
                    for (int p = 0; p < NP; p++) if (exp_wave[p] == w) g = 1;
                if (g) age[s][w] = 0;
                else if (age[s][w] < AMAX) age[s][w]++;
            end
            if (exp_issue && s == exp_simd && exp_wave[1] >= 0) busy[s] = VC - 1;
            else if (busy[s] > 0) busy[s]--;
        end
        if (exp_issue) ptr = (exp_simd + 1) % NS;
    endtask

    task automatic gen(int mode, int cyc);
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                rdy[s][w] = 0; typ[s][w] = 0;
                case (mode)
                    1: begin rdy[s][w] = $urandom_range(0, 1); typ[s][w] = $urandom_range(0, 7); end
                    2: begin rdy[s][w] = ($urandom_range(0, 7) == 0); typ[s][w] = $urandom_range(0, 4); end
                    3: if (s == 0 && w < 6) begin
                           rdy[s][w] = ($urandom_range(0, 3) != 0);
                           typ[s][w] = ($urandom_range(0, 3) == 0) ? 1 : 2;
                       end
                    4: begin
                           rdy[s][w] = ($urandom_range(0, 2) == 0);
                           typ[s][w] = ($urandom_range(0, 3) != 0) ? 2 : $urandom_range(0, 4);
                       end
                    5: if (s == 0) begin rdy[s][w] = 1; typ[s][w] = (w % 5); end
                    6: begin rdy[s][w] = ($urandom_range(0, 3) == 0); typ[s][w] = 5 + (w % 3); end
                    default: ;
                endcase
            end
        if (mode == 6 && cyc % 2 == 0) begin rdy[1][7] = 1; typ[1][7] = 3; end
    endtask

    task automatic drive();
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                wave_rdy[s*NW + w] = rdy[s][w];
                wave_kind[(s*NW + w)*3 +: 3] = 3'(typ[s][w]);
            end
    endtask

    task automatic step(int mode, int cyc, string ph);
        @(negedge clk);
        gen(mode, cyc);
        drive();
        #1;
        model_eval();
        chk(int'(issue_vld), int'(exp_issue), "R1", ph, "issue valid");
        if (exp_issue) chk(int'(issue_simd), exp_simd, "R1", ph, "served simd");
        for (int p = 0; p < NP; p++) begin
            chk(int'(gnt_vld[p]), int'(exp_wave[p] >= 0), port_tag[p], ph, $sformatf("port %0d valid", p));
            if (exp_wave[p] >= 0)
                chk(int'(gnt_wave[p*5 +: 5]), exp_wave[p], port_tag[p], ph, $sformatf("port %0d wave", p));
        end
        if (gnt_vld[1] && gnt_vld[2])
            chk(int'(gnt_wave[5 +: 5] != gnt_wave[10 +: 5]), 1, "R7", ph, "pair distinct");
        model_update();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wave_rdy = '0;
        repeat (3) @(negedge clk);
        model_reset();
        rst = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        do_reset();
        step(0, 0, "R9");                                   // idle after reset
        step(5, 0, "R9");                                   // all ages tie: lowest index per kind
        for (int i = 0; i < 400; i++) step(1, i, "R3");     // dense mix incl. unknown kinds
        for (int i = 0; i < 300; i++) step(2, i, "R8");     // sparse readiness
        for (int i = 0; i < 300; i++) step(3, i, "R6");     // lone SIMD, vector-only
        for (int i = 0; i < 300; i++) step(4, i, "R5");     // FP32-heavy pairing
        for (int i = 0; i < 200; i++) step(6, i, "R8");     // only unused kind codes
        for (int i = 0; i < 40; i++)  step(5, i, "R3");     // fixed pattern, age rotation
        do_reset();
        step(5, 0, "R9");                                   // reset clears ages mid-run
        for (int i = 0; i < 200; i++) step(1, i, "R1");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule